// File: doc/BRIEF.md
# Parallel I/O Register Block with Internal Loopback

This block is the register front end of a 32-channel parallel digital I/O card. A host reaches it over a simple synchronous strobe bus (address, 16-bit write data, byte enables, read and write strobes, 16-bit read data and a one-cycle acknowledge). The upper address bits are compared with two jumper values. One value opens a group of data registers, and the other opens a group holding a control/status word and a fixed board identity word. The 32 output lines are held in four byte-wide port registers. They reach the pins only while the driver enable bit is set. A fail indicator output is driven low while the fault bit is clear.

The block has a self-test path. While loopback is selected, a read of a data port returns the byte last written to it. With loopback off, the same read returns the live input pins, laid out in the same bit positions. Software can therefore check the register path with no external wiring, and can then check the external path with a cable in place.

A bus state machine with three named states sequences each access. ST_IDLE waits for a strobe. On a decode hit, the transition IDLE_TO_RESP commits the write or captures the read word, and the machine enters ST_RESP, where the acknowledge is high for exactly one cycle. RESP_TO_HOLD follows when the strobe is still asserted, and RESP_TO_IDLE follows when it is not. ST_HOLD waits until both strobes are low, then takes HOLD_TO_IDLE. A strobe that misses the decode leaves the machine in ST_IDLE.

Top module: `pio_loopback_regs`

## Requirements
- R1: After reset, pin_oe is 0, pin_out is all zeros, fail_led_n is 0 (indicator lit), loopback is selected and every port register and CSR bit is 0.
- R2: A strobe seen in ST_IDLE at an address that hits a group raises bus_ack for exactly one cycle, in the cycle after that edge. No further acknowledge comes until both strobes have been low at a clock edge.
- R3: The data group is hit when bus_addr[15:4] equals data_sel. The control group is hit when bus_addr[15:4] equals csr_sel and does not equal data_sel. Within either group, only offsets 0x0 and 0x2 in bus_addr[3:0] are valid.
- R4: An access whose upper bits match neither jumper value, or whose offset is not 0x0 or 0x2, gives no acknowledge and changes no register or output.
- R5: Data offset 0x0 maps bits 15:8 to port 0 (pins 31:24) and bits 7:0 to port 1 (pins 23:16). Data offset 0x2 maps bits 15:8 to port 2 (pins 15:8) and bits 7:0 to port 3 (pins 7:0). bus_be[1] enables the high byte of a write and bus_be[0] the low byte.
- R6: CSR bit 0 is the driver enable. pin_oe follows it. pin_out shows the port registers when it is 1 and is all zeros when it is 0.
- R7: CSR bit 1 selects the read source. With the bit at 0, data reads return the port registers. With the bit at 1, data reads return pin_in in the same bit positions.
- R8: CSR bit 2 is the fault-clear bit. fail_led_n equals it, so the indicator is lit while the bit is 0.
- R9: Control offset 0x2 reads 0x0100 (identity 0x01 in bits 15:8), and writes to it change nothing.
- R10: A CSR read returns {bits 15:8 user storage, five zeros, bit2, bit1, bit0}. Bits 7:3 ignore writes. bits 15:8 are read/write storage enabled by bus_be[1]. Bits 2:0 are enabled by bus_be[0].
- R11: bus_rdata holds the word selected at the edge where the read strobe was taken, and is valid while bus_ack is high. A write takes priority when both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Access address |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte enables, bit 1 for the high byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle access acknowledge |
| data_sel | input | 12 | Jumper value for the data group |
| csr_sel | input | 12 | Jumper value for the control group |
| pin_in | input | 32 | Live input pins |
| pin_out | output | 32 | Output pin values, gated by the enable |
| pin_oe | output | 1 | Output driver enable |
| fail_led_n | output | 1 | Fail indicator, low means lit |

## Verification
A corrupted port byte appears on pin_out as soon as the drivers are enabled, and appears on the next loopback read even while they are disabled. A wrong control bit changes pin_oe, fail_led_n or the read source on the cycle after the write that set it. A state machine stuck outside ST_IDLE shows as a missing acknowledge on the next access. A machine that fails to wait in ST_HOLD shows as a second acknowledge while a strobe is held. Decode faults show as an acknowledge or an output change on an address that should miss, or as silence on one that should hit.

// File: rtl/pio_pkg.sv
package pio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RESP = 2'd1,
        ST_HOLD = 2'd2
    } bus_state_t;

    localparam logic [7:0] BOARD_ID = 8'h01;
    localparam int         GRP_LSB  = 4;
endpackage

// File: rtl/pio_addr_decode.sv
module pio_addr_decode #(
    parameter int ADDR_W  = 16,
    parameter int GRP_LSB = 4
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [ADDR_W-GRP_LSB-1:0] data_sel,
    input  logic [ADDR_W-GRP_LSB-1:0] csr_sel,
    output logic                      data_hit,
    output logic                      csr_hit,
    output logic                      pair_sel
);
    logic [ADDR_W-GRP_LSB-1:0] hi_bits;
    logic [GRP_LSB-1:0]        lo_bits;
    logic                      offset_ok;

    always_comb begin
        hi_bits   = addr[ADDR_W-1:GRP_LSB];
        lo_bits   = addr[GRP_LSB-1:0];
        offset_ok = (lo_bits == GRP_LSB'(0)) || (lo_bits == GRP_LSB'(2));
        data_hit  = offset_ok && (hi_bits == data_sel);
        csr_hit   = offset_ok && (hi_bits == csr_sel) && (hi_bits != data_sel);
        pair_sel  = lo_bits[1];
    end
endmodule

// File: rtl/pio_port_regs.sv
module pio_port_regs #(
    parameter int PORT_W    = 8,
    parameter int NUM_PORTS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          pair_sel,
    input  logic [1:0]                    be,
    input  logic [2*PORT_W-1:0]           wdata,
    output logic [PORT_W*NUM_PORTS-1:0]   port_q
);
    localparam int IO_W = PORT_W * NUM_PORTS;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam int  PAIR    = p / 2;
        localparam bit  HI_LANE = ((p % 2) == 0);
        localparam int  LANE    = HI_LANE ? 1 : 0;
        logic [PORT_W-1:0] byte_q;
        logic              lane_we;

        always_comb begin
            lane_we = wr_en && (pair_sel == 1'(PAIR)) && be[LANE];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (lane_we) begin
                byte_q <= wdata[LANE*PORT_W +: PORT_W];
            end
        end

        assign port_q[IO_W-1-p*PORT_W -: PORT_W] = byte_q;
    end
endmodule

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       be,
    input  logic [BUS_W-1:0] wdata,
    output logic             drv_en,
    output logic             loop_off,
    output logic             fault_clr,
    output logic [BUS_W-1:0] csr_word
);
    localparam int HALF = BUS_W / 2;

    logic [HALF-1:0] user_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_en    <= 1'b0;
            loop_off  <= 1'b0;
            fault_clr <= 1'b0;
            user_q    <= '0;
        end else if (wr_en) begin
            if (be[0]) begin
                drv_en    <= wdata[0];
                loop_off  <= wdata[1];
                fault_clr <= wdata[2];
            end
            if (be[1]) begin
                user_q <= wdata[BUS_W-1:HALF];
            end
        end
    end

    always_comb begin
        csr_word = {user_q, {(HALF-3){1'b0}}, fault_clr, loop_off, drv_en};
    end
endmodule

// File: rtl/pio_loopback_regs.sv
module pio_loopback_regs #(
    parameter int ADDR_W = 16,
    parameter int BUS_W  = 16,
    parameter int IO_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    input  logic [1:0]            bus_be,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    output logic [BUS_W-1:0]      bus_rdata,
    output logic                  bus_ack,
    input  logic [ADDR_W-5:0]     data_sel,
    input  logic [ADDR_W-5:0]     csr_sel,
    input  logic [IO_W-1:0]       pin_in,
    output logic [IO_W-1:0]       pin_out,
    output logic                  pin_oe,
    output logic                  fail_led_n
);
    import pio_pkg::*;

    localparam int PORT_W    = BUS_W / 2;
    localparam int NUM_PORTS = IO_W / PORT_W;

    bus_state_t state_q, state_d;

    logic             data_hit, csr_hit, pair_sel;
    logic             take, take_wr, take_rd;
    logic             data_we, csr_we;
    logic [IO_W-1:0]  port_q;
    logic             drv_en, loop_off, fault_clr;
    logic [BUS_W-1:0] csr_word;
    logic [IO_W-1:0]  read_src;
    logic [BUS_W-1:0] rd_word;
    logic [BUS_W-1:0] rdata_q;

    pio_addr_decode #(.ADDR_W(ADDR_W), .GRP_LSB(GRP_LSB)) u_dec (
        .addr     (bus_addr),
        .data_sel (data_sel),
        .csr_sel  (csr_sel),
        .data_hit (data_hit),
        .csr_hit  (csr_hit),
        .pair_sel (pair_sel)
    );

    // Transition conditions
    always_comb begin
        take    = (state_q == ST_IDLE) && (bus_wr || bus_rd) && (data_hit || csr_hit);
        take_wr = take && bus_wr;
        take_rd = take && !bus_wr;
        data_we = take_wr && data_hit;
        csr_we  = take_wr && csr_hit && !pair_sel;
    end

    pio_port_regs #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_ports (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (data_we),
        .pair_sel (pair_sel),
        .be       (bus_be),
        .wdata    (bus_wdata),
        .port_q   (port_q)
    );

    pio_ctrl_reg #(.BUS_W(BUS_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (csr_we),
        .be        (bus_be),
        .wdata     (bus_wdata),
        .drv_en    (drv_en),
        .loop_off  (loop_off),
        .fault_clr (fault_clr),
        .csr_word  (csr_word)
    );

    // Read word selection
    always_comb begin
        read_src = loop_off ? pin_in : port_q;
        if (data_hit) begin
            rd_word = pair_sel ? read_src[BUS_W-1:0] : read_src[IO_W-1 -: BUS_W];
        end else if (pair_sel) begin
            rd_word = {BOARD_ID, {(BUS_W-8){1'b0}}};
        end else begin
            rd_word = csr_word;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: IDLE_TO_RESP, RESP_TO_HOLD, RESP_TO_IDLE, HOLD_TO_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take) state_d = ST_RESP;
            ST_RESP: state_d = (bus_wr || bus_rd) ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (!bus_wr && !bus_rd) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (take_rd) begin
            rdata_q <= rd_word;
        end
    end

    always_comb begin
        bus_ack    = (state_q == ST_RESP);
        bus_rdata  = rdata_q;
        pin_oe     = drv_en;
        pin_out    = drv_en ? port_q : '0;
        fail_led_n = fault_clr;
    end
endmodule

// File: rtl/pio_loopback_regs_chk.sv
module pio_loopback_regs_chk #(
    parameter int ADDR_W = 16,
    parameter int BUS_W  = 16,
    parameter int IO_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [1:0]        bus_be,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              bus_ack,
    input logic [ADDR_W-5:0] data_sel,
    input logic [ADDR_W-5:0] csr_sel,
    input logic [IO_W-1:0]   pin_in,
    input logic [IO_W-1:0]   pin_out,
    input logic              pin_oe,
    input logic              fail_led_n
);
    logic off_ok, miss, id_hit;

    always_comb begin
        off_ok = (bus_addr[3:0] == 4'h0) || (bus_addr[3:0] == 4'h2);
        miss   = !(off_ok && ((bus_addr[ADDR_W-1:4] == data_sel) ||
                              (bus_addr[ADDR_W-1:4] == csr_sel)));
        id_hit = (bus_addr[3:0] == 4'h2) && (bus_addr[ADDR_W-1:4] == csr_sel) &&
                 (bus_addr[ADDR_W-1:4] != data_sel);
    end

    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R4
    miss_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && miss && !bus_ack) |=> !bus_ack);

    // R4
    miss_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && miss) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(fail_led_n)));

    // R6
    out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> (pin_out == '0));

    // R10
    idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pin_out) && $stable(pin_oe) && $stable(fail_led_n)));

    // R9
    id_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && $past(bus_rd && !bus_wr && id_hit)) |-> (bus_rdata == 16'h0100));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ack && !bus_rd) |=> $stable(bus_rdata));
endmodule

bind pio_loopback_regs pio_loopback_regs_chk #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .IO_W(IO_W)
) chk_i (.*);

// File: tb/pio_loopback_regs_tb_top.sv
`timescale 1ns/100ps
module pio_loopback_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [1:0]  bus_be;
    logic        bus_wr, bus_rd;
    logic [15:0] bus_rdata;
    logic        bus_ack;
    logic [11:0] data_sel = 12'hA5C;
    logic [11:0] csr_sel  = 12'h3F1;
    logic [31:0] pin_in;
    logic [31:0] pin_out;
    logic        pin_oe, fail_led_n;

    always #2.5 clk = ~clk;

    pio_loopback_regs dut_i (.*);

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] pm [4];
    logic       m_en, m_loopoff, m_fclr;
    logic [7:0] m_user;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // 0 miss, 1 data, 2 csr group
    function automatic int group_of(logic [15:0] a);
        if (!(a[3:0] == 4'h0 || a[3:0] == 4'h2)) return 0;
        if (a[15:4] == data_sel) return 1;
        if (a[15:4] == csr_sel) return 2;
        return 0;
    endfunction

    function automatic logic [15:0] exp_read(logic [15:0] a);
        logic [31:0] src;
        src = m_loopoff ? pin_in : {pm[0], pm[1], pm[2], pm[3]};
        if (group_of(a) == 1) return a[1] ? src[15:0] : src[31:16];
        if (a[1]) return 16'h0100;
        return {m_user, 5'b0, m_fclr, m_loopoff, m_en};
    endfunction

    function automatic logic [31:0] exp_pins();
        return m_en ? {pm[0], pm[1], pm[2], pm[3]} : 32'h0;
    endfunction

    task automatic model_write(logic [15:0] a, logic [15:0] d, logic [1:0] be);
        int g;
        g = group_of(a);
        if (g == 1) begin
            if (be[1]) pm[a[1] ? 2 : 0] = d[15:8];
            if (be[0]) pm[a[1] ? 3 : 1] = d[7:0];
        end else if (g == 2 && !a[1]) begin
            if (be[0]) begin m_en = d[0]; m_loopoff = d[1]; m_fclr = d[2]; end
            if (be[1]) m_user = d[15:8];
        end
    endtask

    task automatic check_pins(string req);
        check({req, " pin_out"}, pin_out, exp_pins());
        check("R6 pin_oe", {31'b0, pin_oe}, {31'b0, m_en});
        check("R8 fail_led_n", {31'b0, fail_led_n}, {31'b0, m_fclr});
    endtask

    task automatic access(bit wr, logic [15:0] a, logic [15:0] d, logic [1:0] be, string req);
        logic [15:0] er;
        int g;
        g  = group_of(a);
        er = exp_read(a);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = wr; bus_rd = !wr;
        @(negedge clk);
        check({req, " ack"}, {31'b0, bus_ack}, {31'b0, (g != 0)});
        if (!wr && g != 0) check({req, " rdata"}, {16'b0, bus_rdata}, {16'b0, er});
        if (wr) model_write(a, d, be);
        bus_wr = 1'b0; bus_rd = 1'b0;
        @(negedge clk);
        check_pins(req);
    endtask

    localparam logic [15:0] D0 = 16'hA5C0, D2 = 16'hA5C2;
    localparam logic [15:0] C0 = 16'h3F10, C2 = 16'h3F12;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        foreach (pm[i]) pm[i] = 8'h00;
        m_en = 0; m_loopoff = 0; m_fclr = 0; m_user = 8'h00;
        bus_addr = '0; bus_wdata = '0; bus_be = 2'b11; bus_wr = 0; bus_rd = 0;
        pin_in = 32'h1234_5678;
        rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 pin_oe", {31'b0, pin_oe}, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 fail_led_n", {31'b0, fail_led_n}, 32'h0);
        access(0, C0, 0, 2'b11, "R1 R10 csr reset read");
        access(0, D0, 0, 2'b11, "R1 R7 port reset loopback");

        // R5 R6 byte lanes while drivers off
        access(1, D0, 16'hDEAD, 2'b11, "R5 R6 write pair0");
        access(1, D2, 16'hBEEF, 2'b10, "R5 write port2 only");
        access(1, D2, 16'h1177, 2'b01, "R5 write port3 only");
        access(0, D0, 0, 2'b11, "R5 R7 loopback pair0");
        access(0, D2, 0, 2'b11, "R5 R7 loopback pair1");

        // R6 enable drivers, R8 clear fault, R10 unused bits
        access(1, C0, 16'h5AFD, 2'b11, "R6 R8 R10 csr write");
        access(0, C0, 0, 2'b11, "R10 csr readback");
        access(1, C0, 16'h0005, 2'b01, "R7 loopback on");
        access(0, D0, 0, 2'b11, "R7 loopback read");

        // R7 live inputs
        pin_in = 32'hC3A5_0F96;
        access(1, C0, 16'h0007, 2'b01, "R7 loopback off");
        access(0, D0, 0, 2'b11, "R7 pin_in pair0");
        access(0, D2, 0, 2'b11, "R7 pin_in pair1");

        // R9 identity and ignored write
        access(0, C2, 0, 2'b11, "R9 id read");
        access(1, C2, 16'hFFFF, 2'b11, "R9 id write ignored");
        access(0, C2, 0, 2'b11, "R9 id reread");
        access(0, C0, 0, 2'b11, "R9 csr unchanged");

        // R3 R4 misses
        access(1, 16'h0000, 16'hFFFF, 2'b11, "R4 miss hi write");
        access(1, 16'hA5C4, 16'h0000, 2'b11, "R4 bad offset write");
        access(1, 16'h3F11, 16'h0000, 2'b11, "R4 odd offset write");
        access(0, 16'h1230, 0, 2'b11, "R3 R4 miss read");

        // R2 held strobe gives a single ack
        @(negedge clk);
        bus_addr = C2; bus_rd = 1;
        @(negedge clk);
        check("R2 held ack first", {31'b0, bus_ack}, 32'h1);
        check("R11 held rdata", {16'b0, bus_rdata}, 32'h0100);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R2 held ack none", {31'b0, bus_ack}, 32'h0);
        end
        bus_rd = 0;
        @(negedge clk);

        // R11 write wins over read
        @(negedge clk);
        bus_addr = D0; bus_wdata = 16'h2468; bus_be = 2'b11; bus_wr = 1; bus_rd = 1;
        @(negedge clk);
        model_write(D0, 16'h2468, 2'b11);
        check("R11 wr priority ack", {31'b0, bus_ack}, 32'h1);
        bus_wr = 0; bus_rd = 0;
        @(negedge clk);
        check_pins("R11 wr priority");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [15:0] a;
            int k;
            k = $urandom % 10;
            pin_in = $urandom;
            case (k)
                0, 1, 2, 3: a = $urandom_range(1, 0) ? D2 : D0;
                4, 5:       a = C0;
                6:          a = C2;
                7:          a = {data_sel, 4'($urandom_range(15, 0))};
                default:    a = 16'($urandom);
            endcase
            access(($urandom % 2) == 1, a, 16'($urandom), 2'($urandom_range(3, 1)),
                   "R3 R5 R7 R10 random");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule